// File: doc/BRIEF.md
# Two-Level Nested Interrupt Acknowledge Controller

This block decides which pending maskable interrupt request a small CPU core takes, and at which instruction boundary. Each source has a pending bit, a mask bit and a one-bit priority level. A global enable flag and an in-service level flag decide which requests may be taken. Taking any interrupt clears the enable flag. A handler that wants to be interrupted again must execute an enable strobe, and even then only requests at a level equal to or above the one in service are accepted.

The flags are saved on a small internal stack every time an interrupt is taken and restored by the return strobe, so services can nest. After a return, the interrupted program must complete at least one instruction before another maskable request is taken. A software interrupt strobe is always accepted. It saves the flags the same way and clears the enable flag. Instruction fetch, vectors and the datapath belong to the core.

All outputs are registered. An acceptance decided in one clock cycle shows on the outputs in the next cycle.

Top module: `nest_irq_ctrl`

## Requirements
- R1: Any acceptance (maskable or software) leaves `ie_o` at 0 in the cycle its acknowledge pulse shows. `ie_o` then stays 0 until an enable strobe or a return restores it.
- R2: `ie_o` resets to 0. An `ei_i` cycle sets it and a `di_i` cycle clears it. An acceptance in the same cycle as `ei_i` wins, and `ie_o` ends at 0.
- R3: Priority bit 0 means high and 1 means low. `isp_o` resets to 1. After a maskable acknowledge, `isp_o` equals the priority bit of the accepted source.
- R4: While `isp_o` is 0, only sources with priority bit 0 can be acknowledged. Eligible low-priority requests stay pending.
- R5: While `isp_o` is 1, both levels can be acknowledged. Every eligible high-priority source beats every low-priority one, and within a level the lowest index wins.
- R6: A `req_i` bit sets the pending bit, which holds until that source is acknowledged or its `clr_i` bit is set. A request in the same cycle as a clear leaves the bit set.
- R7: A source whose mask bit is 1 is never acknowledged. Its pending bit is kept, so it is taken after being unmasked.
- R8: A maskable request is accepted only in a cycle with `instr_done_i` high. It then gives a one-cycle `ack_o` with `ack_id_o` in the next cycle. `ack_id_o` is 0 when no acknowledge is shown.
- R9: No maskable acceptance happens in a `reti_i` cycle, nor at the first `instr_done_i` cycle after it. Acceptance is possible again from the following boundary.
- R10: Every acceptance pushes {enable, in-service} onto a stack of STACK_DEPTH entries (default 4). `reti_i` pops both flags. A return on an empty stack leaves both flags unchanged. While the stack is full, maskable acceptance is blocked.
- R11: `swi_i` is accepted in its own cycle whatever the enable flag, boundary strobe or stack state. It gives a one-cycle `ack_sw_o`, clears the enable flag, leaves `isp_o` unchanged and pushes the flags unless the stack is full. It takes precedence over a maskable acceptance in the same cycle, and that request stays pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | NSRC | Request pulses, one per source |
| clr_i | input | NSRC | Pending-bit clear, one per source |
| mask_i | input | NSRC | 1 = source masked |
| prio_i | input | NSRC | Priority level, 0 = high, 1 = low |
| instr_done_i | input | 1 | Instruction boundary strobe |
| ei_i | input | 1 | Enable-interrupts strobe |
| di_i | input | 1 | Disable-interrupts strobe |
| reti_i | input | 1 | Return-from-interrupt strobe |
| swi_i | input | 1 | Software interrupt strobe |
| ack_o | output | 1 | Maskable acknowledge pulse |
| ack_id_o | output | max(1,clog2(NSRC)) | Index of the acknowledged source |
| ack_sw_o | output | 1 | Software interrupt acknowledge pulse |
| ie_o | output | 1 | Global enable flag |
| isp_o | output | 1 | In-service level flag |

## Verification
The bench builds the block with NSRC = 5 and STACK_DEPTH = 3. A three-deep stack fills after three nested acceptances, so the full-stack blocking and the dropped save of a software interrupt are reached within a short directed sequence. Five sources with mixed priority bits give both levels several members, which exercises the level ordering and the index ordering within a level. A long randomized phase of strobes, mask and priority changes is then compared on every clock against a behavioural model.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef struct packed {
    logic ie;
    logic isp;
  } flags_t;
endpackage

// File: rtl/irq_pending.sv
module irq_pending #(
  parameter int NSRC = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] req_i,
  input  logic [NSRC-1:0] clr_i,
  input  logic [NSRC-1:0] take_i,
  output logic [NSRC-1:0] pend_o
);
  logic [NSRC-1:0] pend_q;
  logic [NSRC-1:0] keep;

  // per-source pending latch: request dominates clear and take
  for (genvar g = 0; g < NSRC; g++) begin : g_bit
    assign keep[g] = pend_q[g] & ~clr_i[g] & ~take_i[g];
    always_ff @(posedge clk) begin
      if (rst) pend_q[g] <= 1'b0;
      else     pend_q[g] <= keep[g] | req_i[g];
    end
  end

  assign pend_o = pend_q;

  // R6: a kept bit is never lost
  p_pending_held_r6: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pend_q & $past(keep)) == $past(keep)));
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int NSRC = 8,
  localparam int IDW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic [NSRC-1:0] pend_i,
  input  logic [NSRC-1:0] mask_i,
  input  logic [NSRC-1:0] prio_i,
  input  logic            allow_low_i,
  output logic            valid_o,
  output logic [IDW-1:0]  id_o,
  output logic            lvl_o
);
  logic [NSRC-1:0] elig_hi, elig_lo;
  logic [IDW-1:0]  id_hi, id_lo;

  for (genvar g = 0; g < NSRC; g++) begin : g_elig
    assign elig_hi[g] = pend_i[g] & ~mask_i[g] & ~prio_i[g];
    assign elig_lo[g] = pend_i[g] & ~mask_i[g] &  prio_i[g] & allow_low_i;
  end

  // lowest index wins inside a level
  always_comb begin
    id_hi = '0;
    id_lo = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (elig_hi[i]) id_hi = IDW'(i);
      if (elig_lo[i]) id_lo = IDW'(i);
    end
  end

  assign valid_o = (|elig_hi) | (|elig_lo);
  assign id_o    = (|elig_hi) ? id_hi : id_lo;
  assign lvl_o   = ~(|elig_hi);
endmodule

// File: rtl/irq_flag_stack.sv
module irq_flag_stack
  import irq_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int AW  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int SPW = $clog2(DEPTH + 1)
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   push_i,
  input  logic   pop_i,
  input  flags_t din_i,
  output flags_t top_o,
  output logic   full_o,
  output logic   empty_o
);
  flags_t         mem [DEPTH];
  logic [SPW-1:0] sp_q;
  logic [AW-1:0]  wr_idx, rd_idx;

  assign full_o  = (sp_q == SPW'(DEPTH));
  assign empty_o = (sp_q == '0);
  assign wr_idx  = AW'(sp_q);
  assign rd_idx  = empty_o ? '0 : AW'(sp_q - 1'b1);

  // storage without reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (push_i && !full_o) mem[wr_idx] <= din_i;
  end

  always_ff @(posedge clk) begin
    if (rst)                     sp_q <= '0;
    else if (push_i && !full_o)  sp_q <= sp_q + 1'b1;
    else if (pop_i && !empty_o)  sp_q <= sp_q - 1'b1;
  end

  assign top_o = mem[rd_idx];

  p_no_overflow_r10: assert property (@(posedge clk) disable iff (rst)
    sp_q <= SPW'(DEPTH));
  p_full_stays_r10: assert property (@(posedge clk) disable iff (rst)
    (full_o && !pop_i) |=> full_o);
endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl
  import irq_pkg::*;
#(
  parameter int NSRC        = 8,
  parameter int STACK_DEPTH = 4,
  localparam int IDW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] req_i,
  input  logic [NSRC-1:0] clr_i,
  input  logic [NSRC-1:0] mask_i,
  input  logic [NSRC-1:0] prio_i,
  input  logic            instr_done_i,
  input  logic            ei_i,
  input  logic            di_i,
  input  logic            reti_i,
  input  logic            swi_i,
  output logic            ack_o,
  output logic [IDW-1:0]  ack_id_o,
  output logic            ack_sw_o,
  output logic            ie_o,
  output logic            isp_o
);
  logic            ie_q, isp_q, hold_q;
  logic [NSRC-1:0] pend, take;
  logic            win_valid, win_lvl;
  logic [IDW-1:0]  win_id;
  logic            st_full, st_empty;
  flags_t          st_top, st_din;
  logic            gate, take_mask, sw_take, push, pop;

  irq_pending #(.NSRC(NSRC)) u_pend (
    .clk(clk), .rst(rst), .req_i(req_i), .clr_i(clr_i),
    .take_i(take), .pend_o(pend)
  );

  irq_pick #(.NSRC(NSRC)) u_pick (
    .pend_i(pend), .mask_i(mask_i), .prio_i(prio_i), .allow_low_i(isp_q),
    .valid_o(win_valid), .id_o(win_id), .lvl_o(win_lvl)
  );

  assign st_din = '{ie: ie_q, isp: isp_q};

  irq_flag_stack #(.DEPTH(STACK_DEPTH)) u_stack (
    .clk(clk), .rst(rst), .push_i(push), .pop_i(pop), .din_i(st_din),
    .top_o(st_top), .full_o(st_full), .empty_o(st_empty)
  );

  // maskable acceptance window
  assign gate      = ie_q & instr_done_i & ~hold_q & ~reti_i & ~swi_i & ~st_full;
  assign take_mask = gate & win_valid;
  assign sw_take   = swi_i;
  assign push      = take_mask | sw_take;
  assign pop       = reti_i & ~sw_take;

  always_comb begin
    take = '0;
    if (take_mask) take[win_id] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ie_q     <= 1'b0;
      isp_q    <= 1'b1;
      hold_q   <= 1'b0;
      ack_o    <= 1'b0;
      ack_id_o <= '0;
      ack_sw_o <= 1'b0;
    end else begin
      ack_o    <= take_mask;
      ack_sw_o <= sw_take;
      ack_id_o <= take_mask ? win_id : '0;
      if (sw_take) begin
        ie_q <= 1'b0;
      end else if (take_mask) begin
        ie_q  <= 1'b0;
        isp_q <= win_lvl;
      end else if (pop) begin
        if (!st_empty) begin
          ie_q  <= st_top.ie;
          isp_q <= st_top.isp;
        end
      end else if (ei_i) begin
        ie_q <= 1'b1;
      end else if (di_i) begin
        ie_q <= 1'b0;
      end
      if (reti_i)            hold_q <= 1'b1;
      else if (instr_done_i) hold_q <= 1'b0;
    end
  end

  assign ie_o  = ie_q;
  assign isp_o = isp_q;

  p_ack_clears_ie_r1: assert property (@(posedge clk) disable iff (rst)
    (ack_o || ack_sw_o) |-> !ie_q);
  p_ie_stays_clear_r1: assert property (@(posedge clk) disable iff (rst)
    (!ie_q && !ei_i && !reti_i) |=> !ie_q);
  p_level_gate_r4: assert property (@(posedge clk) disable iff (rst)
    (win_valid && !isp_q) |-> !prio_i[win_id]);
  p_masked_never_r7: assert property (@(posedge clk) disable iff (rst)
    win_valid |-> !mask_i[win_id]);
  p_boundary_only_r8: assert property (@(posedge clk) disable iff (rst)
    ack_o |-> $past(instr_done_i));
  p_hold_blocks_r9: assert property (@(posedge clk) disable iff (rst)
    ack_o |-> !$past(hold_q));
  p_one_kind_r11: assert property (@(posedge clk) disable iff (rst)
    !(ack_o && ack_sw_o));
endmodule

// File: tb/nest_irq_ctrl_test.sv
`timescale 1ns/1ps
module nest_irq_ctrl_test;
  localparam int NS  = 5;
  localparam int DEP = 3;
  localparam int IDW = $clog2(NS);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NS-1:0] req = '0, clr = '0, mask = '0, prio = '0;
  logic instr = 1'b0, ei = 1'b0, di = 1'b0, reti = 1'b0, swi = 1'b0;
  logic ack, ack_sw, ie, isp;
  logic [IDW-1:0] ack_id;

  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  nest_irq_ctrl #(.NSRC(NS), .STACK_DEPTH(DEP)) uut (
    .clk(clk), .rst(rst), .req_i(req), .clr_i(clr), .mask_i(mask), .prio_i(prio),
    .instr_done_i(instr), .ei_i(ei), .di_i(di), .reti_i(reti), .swi_i(swi),
    .ack_o(ack), .ack_id_o(ack_id), .ack_sw_o(ack_sw), .ie_o(ie), .isp_o(isp)
  );

  // ---------------- behavioural reference ----------------
  bit [NS-1:0] m_pend;
  bit m_ie, m_isp, m_hold, m_ack, m_sw;
  int m_id, win;
  bit [1:0] m_stk[$];

  always @(posedge clk) begin
    if (rst) begin
      m_pend = '0; m_ie = 0; m_isp = 1; m_hold = 0;
      m_ack = 0; m_sw = 0; m_id = 0; m_stk.delete();
    end else begin
      win = -1;
      if (m_ie && instr && !m_hold && !reti && !swi && m_stk.size() < DEP) begin
        for (int i = 0; i < NS; i++)
          if (win < 0 && m_pend[i] && !mask[i] && !prio[i]) win = i;
        if (win < 0 && m_isp)
          for (int i = 0; i < NS; i++)
            if (win < 0 && m_pend[i] && !mask[i]) win = i;
      end
      m_ack = 0; m_sw = 0; m_id = 0;
      if (swi) begin
        if (m_stk.size() < DEP) m_stk.push_back({m_ie, m_isp});
        m_ie = 0; m_sw = 1;
      end else if (win >= 0) begin
        m_stk.push_back({m_ie, m_isp});
        m_ie = 0; m_isp = prio[win]; m_ack = 1; m_id = win;
      end else if (reti) begin
        if (m_stk.size() > 0) begin
          bit [1:0] f;
          f = m_stk.pop_back();
          m_ie = f[1]; m_isp = f[0];
        end
      end else if (ei) m_ie = 1;
      else if (di) m_ie = 0;
      if (reti) m_hold = 1; else if (instr) m_hold = 0;
      for (int i = 0; i < NS; i++)
        m_pend[i] = (m_pend[i] && !clr[i] && !(win == i)) || req[i];
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // per-clock comparison against the reference
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R5 model ack",    ack,    m_ack);
      chk("R5 model ack_id", ack_id, m_id);
      chk("R11 model ack_sw", ack_sw, m_sw);
      chk("R1 model ie",     ie,     m_ie);
      chk("R3 model isp",    isp,    m_isp);
    end
  end

  task automatic tick();
    @(negedge clk);
    req = '0; clr = '0; instr = 0; ei = 0; di = 0; reti = 0; swi = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    prio = 5'b01010;
    repeat (4) @(negedge clk);
    rst = 0;
    chk("R2 reset ie", ie, 0);
    chk("R3 reset isp", isp, 1);
    chk("R8 reset ack", ack, 0);

    req = 5'b01000; instr = 1; tick();
    chk("R6 no ack while disabled", ack, 0);
    instr = 1; tick();
    chk("R6 still held", ack, 0);
    ei = 1; tick();
    chk("R2 ei sets", ie, 1);
    instr = 1; tick();
    chk("R1 ack 3", ack, 1); chk("R8 id 3", ack_id, 3);
    chk("R1 ie cleared", ie, 0); chk("R3 isp low", isp, 1);

    req = 5'b10010; tick();
    ei = 1; tick();
    chk("R8 no boundary no ack", ack, 0);
    instr = 1; tick();
    chk("R5 high beats low", ack_id, 4); chk("R3 isp high", isp, 0);
    ei = 1; tick();
    instr = 1; tick();
    chk("R4 low held at isp 0", ack, 0);
    req = 5'b00100; tick();
    instr = 1; tick();
    chk("R4 high taken", ack, 1); chk("R4 id 2", ack_id, 2);

    ei = 1; tick();
    req = 5'b00001; tick();
    instr = 1; tick();
    chk("R10 full blocks", ack, 0);
    swi = 1; tick();
    chk("R11 swi when full", ack_sw, 1);
    chk("R11 swi clears ie", ie, 0); chk("R11 isp kept", isp, 0);
    reti = 1; tick();
    chk("R10 pop ie", ie, 1); chk("R10 pop isp", isp, 0);
    instr = 1; tick();
    chk("R9 first boundary blocked", ack, 0);
    instr = 1; tick();
    chk("R9 second boundary", ack, 1); chk("R9 id 0", ack_id, 0);

    reti = 1; tick();
    reti = 1; tick();
    chk("R10 nested pop isp", isp, 1);
    reti = 1; tick();
    di = 1; tick();
    chk("R2 di clears", ie, 0);
    reti = 1; tick();
    chk("R10 empty pop ie", ie, 0); chk("R10 empty pop isp", isp, 1);

    mask = 5'b00010;
    ei = 1; tick();
    instr = 1; tick();
    instr = 1; tick();
    chk("R7 masked not taken", ack, 0);
    mask = '0;
    instr = 1; tick();
    chk("R7 taken after unmask", ack_id, 1); chk("R7 ack", ack, 1);

    ei = 1; tick();
    req = 5'b00100; tick();
    clr = 5'b00100; tick();
    instr = 1; tick();
    chk("R6 cleared not taken", ack, 0);
    req = 5'b10000; clr = 5'b10000; tick();
    instr = 1; tick();
    chk("R6 req beats clr", ack_id, 4);

    ei = 1; tick();
    req = 5'b00001; tick();
    swi = 1; instr = 1; tick();
    chk("R11 swi precedence", ack_sw, 1); chk("R11 no maskable", ack, 0);
    reti = 1; tick();
    instr = 1; tick();
    instr = 1; tick();
    chk("R11 request kept", ack_id, 0); chk("R11 ack after", ack, 1);

    for (int c = 0; c < 3000; c++) begin
      req   = ($urandom_range(0, 3) == 0) ? NS'($urandom) : '0;
      clr   = ($urandom_range(0, 15) == 0) ? NS'($urandom) : '0;
      instr = $urandom_range(0, 1);
      ei    = ($urandom_range(0, 4) == 0);
      di    = ($urandom_range(0, 19) == 0);
      reti  = ($urandom_range(0, 9) == 0);
      swi   = ($urandom_range(0, 29) == 0);
      if ($urandom_range(0, 49) == 0) mask = NS'($urandom) & NS'($urandom);
      if ($urandom_range(0, 49) == 0) prio = NS'($urandom);
      tick();
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule